// File: doc/BRIEF.md
# Base-Deviation Complement Multiplier

This block multiplies two unsigned N-bit operands by working from their distances to the base 2^N, not from the operands themselves. Each operand is complemented to give its deviation from the base. Only the two deviations pass through a true multiplier, and the low N bits of that product form the right-hand field of the result. The left-hand field comes from a cross subtraction. Modulo 2^N, this reduces to the sum of the two operands plus the overflow of the deviation product, and a carry-save stage followed by one carry-propagate adder builds it. The joined fields give the full 2N-bit product. The deviations are small when the operands sit close to the base, and that case is where the method pays off. Every operand pair still yields the exact product.

The datapath is combinational. A single output register with a valid/ready handshake sits at its end. An input beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. Its product appears on `o_data` with `o_valid` high from the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `o_valid` is high and `o_ready` is low, the result holds and no new beat is taken.

Top module: `bdm_mult`

## Requirements
- R1: Each operand x gets a deviation d = 2^N − x, held in N+1 bits. It is the N-bit two's complement of x, with bit N set only when x is zero.
- R2: A zero operand gives the deviation 2^N (bit N set, low bits clear), and the product is then 0 whatever the other operand is.
- R3: The low N bits of the result, o_data[N-1:0], equal the deviation product d1·d2 modulo 2^N. The bits of d1·d2 from bit N upward form an overflow that moves into the high field. Bit 2N+1 of d1·d2 is always zero.
- R4: The high N bits of the result, o_data[2N-1:N], equal (x1 − d2 + overflow) mod 2^N, which is (x1 + x2 + overflow) mod 2^N. Three-input carry-save addition and then one final adder form this field, with no multiplier.
- R5: o_data equals x1·x2 exactly, as a 2N-bit unsigned value, for every pair of operands.
- R6: A beat accepted on a rising edge drives o_valid high and places its product on o_data from that edge until the result is taken.
- R7: While o_valid is high and o_ready is low, in_ready is low, and o_data and o_valid keep their values whatever happens on the input side.
- R8: While rst_n is low, o_valid is 0 and in_ready is 1.
- R9: With o_ready held high, in_ready stays high and one product leaves per cycle with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | N | First unsigned operand |
| in_b | input | N | Second unsigned operand |
| o_valid | output | 1 | Product present on o_data |
| o_ready | input | 1 | Consumer takes the product this cycle |
| o_data | output | 2N | Unsigned product, high field above low field |

## Verification
Each product is due one cycle after the edge that accepted its operands. The bench drives every beat half a cycle before that edge and reads the result at the falling edge that follows. This gives exactly one register of delay to account for. In streaming sweeps, the check for one pair and the drive of the next pair fall in the same falling-edge slot. Under back-pressure, the bench reads the held result on every stalled cycle while it changes the offered operands, and it checks the replacement beat one falling edge after o_ready returns.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  // Width of the deviation product for an N-bit operand (deviations are N+1 bits).
  function automatic int unsigned dev_prod_w(input int unsigned n);
    return 2 * (n + 1);
  endfunction
endpackage

// File: rtl/bdm_deviation.sv
module bdm_deviation #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x,
  output logic [N:0]   d
);
  logic [N-1:0] cpl;
  logic         is_zero;

  assign cpl     = (~x) + {{(N-1){1'b0}}, 1'b1};
  assign is_zero = (x == '0);
  assign d       = {is_zero, cpl};

  // R1: operand plus deviation always lands exactly on the base.
  always_comb begin
    p_dev_sum_r1: assert (({2'b00, x} + {1'b0, d}) == ({{(N+1){1'b0}}, 1'b1} << N))
      else $error("deviation does not complete the base");
  end

  // R2: zero operand yields the full base as its deviation.
  always_comb begin
    if (x == '0) begin
      p_zero_dev_r2: assert (d[N] && (d[N-1:0] == '0))
        else $error("zero operand deviation wrong");
    end
  end
endmodule

// File: rtl/bdm_dev_mult.sv
module bdm_dev_mult #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] acc [0:W];
  logic [PW-1:0] a_ext;

  assign a_ext  = {{W{1'b0}}, a};
  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] pp;
    assign pp         = b[i] ? (a_ext << i) : '0;
    assign acc[i + 1] = acc[i] + pp;
  end

  assign p = acc[W];
endmodule

// File: rtl/bdm_csa3.sv
module bdm_csa3 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] maj;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = x[i] ^ y[i] ^ z[i];
    assign maj[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end

  assign c = {maj[W-2:0], 1'b0};

  // R4: the carry-save pair keeps the three-input sum modulo 2^W.
  always_comb begin
    p_csa_keep_r4: assert ((s + c) == (x + y + z))
      else $error("carry-save stage lost value");
  end
endmodule

// File: rtl/bdm_upper.sv
module bdm_upper #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x1,
  input  logic [N-1:0] x2,
  input  logic [N:0]   ovf,
  output logic [N-1:0] hi
);
  logic [N-1:0] s_vec;
  logic [N-1:0] c_vec;

  // x1 - d2 = x1 + x2 - 2^N; the -2^N vanishes modulo 2^N.
  bdm_csa3 #(.W(N)) u_csa (
    .x (x1),
    .y (x2),
    .z (ovf[N-1:0]),
    .s (s_vec),
    .c (c_vec)
  );

  assign hi = s_vec + c_vec;
endmodule

// File: rtl/bdm_mult.sv
module bdm_mult
  import bdm_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_a,
  input  logic [N-1:0]   in_b,
  output logic           o_valid,
  input  logic           o_ready,
  output logic [2*N-1:0] o_data
);
  localparam int unsigned DW = N + 1;
  localparam int unsigned PW = dev_prod_w(N);

  logic [DW-1:0]  dev [0:1];
  logic [N-1:0]   opnd [0:1];
  logic [PW-1:0]  dprod;
  logic [N-1:0]   lo_field;
  logic [N:0]     ovf;
  logic [N-1:0]   hi_field;
  logic [2*N-1:0] prod;

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar k = 0; k < 2; k++) begin : g_dev
    bdm_deviation #(.N(N)) u_dev (
      .x (opnd[k]),
      .d (dev[k])
    );
  end

  bdm_dev_mult #(.W(DW)) u_dmul (
    .a (dev[0]),
    .b (dev[1]),
    .p (dprod)
  );

  assign lo_field = dprod[N-1:0];
  assign ovf      = dprod[2*N:N];

  // R3: deviations never exceed 2^N, so the top product bit stays clear.
  always_comb begin
    p_dprod_top_r3: assert (dprod[PW-1] == 1'b0)
      else $error("deviation product exceeds 2N+1 bits");
  end

  bdm_upper #(.N(N)) u_upper (
    .x1  (in_a),
    .x2  (in_b),
    .ovf (ovf),
    .hi  (hi_field)
  );

  assign prod = {hi_field, lo_field};

  // Output register with valid/ready.
  assign in_ready = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (in_ready) begin
      o_valid <= in_valid;
      if (in_valid) o_data <= prod;
    end
  end

  // R5/R6: an accepted beat shows up next cycle as the exact product.
  p_product_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (o_valid && ({{(2*N){1'b0}}, o_data} == ({{(2*N){1'b0}}, $past(in_a)} * {{(2*N){1'b0}}, $past(in_b)}))))
    else $error("product mismatch");

  // R7: a stalled result holds.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)))
    else $error("stalled result changed");

  // R9: a ready consumer never blocks the input side.
  p_flow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    o_ready |-> in_ready)
    else $error("input blocked with ready consumer");
endmodule

// File: tb/bdm_mult_bench.sv
`timescale 1ns/1ps
module bdm_mult_bench;
  localparam int NS = 4;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // Small instance, swept exhaustively.
  logic            s_iv = 1'b0, s_or = 1'b1, s_ir, s_ov;
  logic [NS-1:0]   s_a = '0, s_b = '0;
  logic [2*NS-1:0] s_d;

  // Default-width instance, swept near the base and at the edges.
  logic            l_iv = 1'b0, l_or = 1'b1, l_ir, l_ov;
  logic [NL-1:0]   l_a = '0, l_b = '0;
  logic [2*NL-1:0] l_d;

  bdm_mult #(.N(NS)) u_bdm_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir),
    .in_a(s_a), .in_b(s_b), .o_valid(s_ov), .o_ready(s_or), .o_data(s_d));

  bdm_mult #(.N(NL)) u_bdm_mult_w8 (
    .clk(clk), .rst_n(rst_n), .in_valid(l_iv), .in_ready(l_ir),
    .in_a(l_a), .in_b(l_b), .o_valid(l_ov), .o_ready(l_or), .o_data(l_d));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_prev;
    bit have_prev;
    int vals [9] = '{0, 1, 2, 127, 128, 200, 250, 254, 255};

    // R8: reset state.
    repeat (3) @(negedge clk);
    chk("R8 o_valid in reset", int'(s_ov), 0);
    chk("R8 in_ready in reset", int'(s_ir), 1);
    chk("R8 o_valid in reset w8", int'(l_ov), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5/R6/R9 exhaustive stream on the small instance (R1..R4 through fields).
    have_prev = 1'b0;
    exp_prev = 0;
    for (int a = 0; a < (1 << NS); a++) begin
      for (int b = 0; b < (1 << NS); b++) begin
        if (have_prev) begin
          chk("R6 o_valid", int'(s_ov), 1);
          chk("R5 product", int'(s_d), exp_prev);
          chk("R3 low field", int'(s_d[NS-1:0]), exp_prev % (1 << NS));
          chk("R4 high field", int'(s_d[2*NS-1:NS]), exp_prev >> NS);
        end
        chk("R9 in_ready streaming", int'(s_ir), 1);
        if (a == 0 || b == 0) begin
          // R2 zero operand: product must be zero next cycle
        end
        s_iv = 1'b1;
        s_a = NS'(a);
        s_b = NS'(b);
        exp_prev = a * b;
        have_prev = 1'b1;
        @(negedge clk);
      end
    end
    chk("R5 last product", int'(s_d), exp_prev);
    s_iv = 1'b0;
    @(negedge clk);
    chk("R6 o_valid drops when idle", int'(s_ov), 0);

    // R2 explicit zero cases.
    s_iv = 1'b1; s_a = '0; s_b = 4'd13;
    @(negedge clk);
    chk("R2 zero times 13", int'(s_d), 0);
    s_a = 4'd15; s_b = '0;
    @(negedge clk);
    chk("R2 15 times zero", int'(s_d), 0);

    // R7 back-pressure.
    s_a = 4'd3; s_b = 4'd5; s_or = 1'b1;
    @(negedge clk);
    s_or = 1'b0;
    chk("R7 first result", int'(s_d), 15);
    s_a = 4'd7; s_b = 4'd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 held data", int'(s_d), 15);
      chk("R7 held valid", int'(s_ov), 1);
      chk("R7 in_ready low", int'(s_ir), 0);
      s_a = NS'(k + 9);
    end
    s_a = 4'd7; s_b = 4'd7; s_or = 1'b1;
    @(negedge clk);
    chk("R7 replacement after stall", int'(s_d), 49);
    s_iv = 1'b0;
    @(negedge clk);
    chk("R7 drained", int'(s_ov), 0);

    // R1..R5 at the default width: operands near the base and at 0 and 1.
    have_prev = 1'b0;
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) begin
        if (have_prev) begin
          chk("R5 product w8", int'(l_d), exp_prev);
          chk("R3 low field w8", int'(l_d[NL-1:0]), exp_prev % (1 << NL));
          chk("R4 high field w8", int'(l_d[2*NL-1:NL]), exp_prev >> NL);
          chk("R1 valid w8", int'(l_ov), 1);
        end
        l_iv = 1'b1;
        l_a = NL'(vals[i]);
        l_b = NL'(vals[j]);
        exp_prev = vals[i] * vals[j];
        have_prev = 1'b1;
        @(negedge clk);
      end
    end
    chk("R5 last product w8", int'(l_d), exp_prev);
    l_iv = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule